// File: doc/BRIEF.md
# Prioritized Vectoring Interrupt Controller

This block gathers thirteen peripheral interrupt request lines, numbered 1 to 13, and presents a single interrupt level and vector number to the processor. Each request line is copied every cycle into a pending register. A mask register then blocks any source whose mask bit is 1. Among the sources that remain, the block picks the one with the largest five-bit priority, taken from the low bits of that source's 8-bit control register. The upper three of those five bits are the interrupt level. The lower two bits order sources that share a level.

The winner's control register also chooses how its vector is formed. With the autovector flag set, the vector is 24 plus the level. Without it, three sources take their vector from dedicated vector registers: source 8 uses the watchdog vector register, and sources 12 and 13 use two serial-port vector registers. Every other source falls back to a fixed vector of 0x0F. Software reaches all of this state through a byte-wide register port. A reset-status register is also on that port, and writing a 1 to one of its bits clears that bit. Level and vector are registered outputs.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, irq_level and irq_vector are 0. The mask reads 0x3FFE. The control registers of sources 1..13 read 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x1C, 0x80, 0x80, 0x80, 0x00, 0x00. The three vector registers read 0x0F and the reset-status register reads 0x80.
- R2: Pending bit n (n = 1..13) equals request line n as sampled at the previous clock edge. Bits 0, 14 and 15 read 0. The pending register is read at byte 0x3A (bits 15:8) and byte 0x3B (bits 7:0), and writes to these bytes are ignored.
- R3: A source whose mask bit is 1 never wins arbitration. The mask is written and read as byte 0x36 (bits 15:8) and byte 0x37 (bits 7:0), and mask bit n belongs to source n.
- R4: Among the unmasked pending sources, the one with the largest control[4:0] wins. When several sources share that value, the lowest-numbered one wins.
- R5: If no source is active, or the winning control[4:0] is below 4, then irq_level = 0 and irq_vector = 0.
- R6: When a source wins, irq_level equals its control[4:2].
- R7: If the winner's control bit 7 is 1, irq_vector = 24 + irq_level.
- R8: If the winner's control bit 7 is 0, irq_vector is taken as follows: source 8 uses the watchdog vector register at 0x42, source 12 uses the serial-port-0 vector register at 0x44, source 13 uses the serial-port-1 vector register at 0x45, and any other source gets 0x0F.
- R9: The control register of source n is read and written at byte address 0x13 + n. Unmapped addresses read 0 and ignore writes.
- R10: The reset-status register at 0x40 clears each bit that is written as 1 and keeps every other bit. It never sets a bit after reset.
- R11: The outputs change one clock edge after a register write takes effect, and two clock edges after a change on a request line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 13 | Request lines; bit n is source n |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_level | output | 3 | Presented interrupt level, 0 = none |
| irq_vector | output | 8 | Presented vector number |

## Verification
The bench pairs two sources that have equal priority. A design that let the later scan position win, or compared with greater-or-equal, would report the higher-numbered source. It programs a winner at level 0 to check that the block stays silent, where a faulty design would present a spurious vector. It also exercises the three dedicated vector sources and a fallback source with the autovector flag cleared, so that any routing mix-up shows up as a wrong vector. Finally, it samples one edge after a request change to catch a design that adds or drops a pipeline stage, and it writes to the pending bytes to show that software cannot forge a request.

// File: rtl/pic_pkg.sv
package pic_pkg;
    // Register byte addresses; the control block base is such that source n sits at CTL_BASE + n
    localparam int CTL_BASE   = 'h13;
    localparam int MASK_HI    = 'h36;
    localparam int MASK_LO    = 'h37;
    localparam int PEND_HI    = 'h3A;
    localparam int PEND_LO    = 'h3B;
    localparam int STAT_ADDR  = 'h40;
    localparam int SWT_VADDR  = 'h42;
    localparam int SP0_VADDR  = 'h44;
    localparam int SP1_VADDR  = 'h45;

    // Sources with dedicated vector registers
    localparam int SWT_SRC    = 8;
    localparam int SP0_SRC    = 12;
    localparam int SP1_SRC    = 13;

    localparam logic [15:0] MASK_RST   = 16'h3FFE;
    localparam logic [7:0]  STAT_RST   = 8'h80;
    localparam logic [7:0]  VEC_RST    = 8'h0F;
    localparam logic [7:0]  VEC_FALLBK = 8'h0F;
    localparam logic [7:0]  AUTOV_BASE = 8'd24;
    localparam logic [4:0]  MIN_PRIO   = 5'd4;

    function automatic logic [7:0] ctl_rst(int n);
        if (n >= 1 && n <= 7)       return 8'(4 * n);
        else if (n == 8)            return 8'h1C;
        else if (n >= 9 && n <= 11) return 8'h80;
        else                        return 8'h00;
    endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int NSRC = 13,
    parameter int AW   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC:1]         irq_req,
    input  logic [AW-1:0]         bus_addr,
    input  logic                  bus_wr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic [NSRC:1][4:0]    src_prio,
    output logic [NSRC:1]         src_auto,
    output logic [15:0]           pend_q,
    output logic [15:0]           mask_q,
    output logic [7:0]            stat_q,
    output logic [7:0]            swt_vec,
    output logic [7:0]            sp0_vec,
    output logic [7:0]            sp1_vec
);
    logic [NSRC:1][7:0] ctl_q;
    logic [15:0]        pend_d;

    function automatic logic hit(logic [AW-1:0] a, int target);
        return a == AW'(target);
    endfunction

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 1; n <= NSRC; n++) ctl_q[n] <= ctl_rst(n);
        end else if (bus_wr) begin
            for (int n = 1; n <= NSRC; n++)
                if (hit(bus_addr, CTL_BASE + n)) ctl_q[n] <= bus_wdata;
        end
    end

    // mask, vectors, reset status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= MASK_RST;
            stat_q  <= STAT_RST;
            swt_vec <= VEC_RST;
            sp0_vec <= VEC_RST;
            sp1_vec <= VEC_RST;
        end else if (bus_wr) begin
            if (hit(bus_addr, MASK_HI))   mask_q[15:8] <= bus_wdata;
            if (hit(bus_addr, MASK_LO))   mask_q[7:0]  <= bus_wdata;
            if (hit(bus_addr, STAT_ADDR)) stat_q       <= stat_q & ~bus_wdata;
            if (hit(bus_addr, SWT_VADDR)) swt_vec      <= bus_wdata;
            if (hit(bus_addr, SP0_VADDR)) sp0_vec      <= bus_wdata;
            if (hit(bus_addr, SP1_VADDR)) sp1_vec      <= bus_wdata;
        end
    end

    // pending tracks request lines
    always_comb begin
        pend_d = '0;
        pend_d[NSRC:1] = irq_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // field split for the arbiter
    for (genvar g = 1; g <= NSRC; g++) begin : g_fld
        assign src_prio[g] = ctl_q[g][4:0];
        assign src_auto[g] = ctl_q[g][7];
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int n = 1; n <= NSRC; n++)
            if (hit(bus_addr, CTL_BASE + n)) bus_rdata = ctl_q[n];
        if (hit(bus_addr, MASK_HI))   bus_rdata = mask_q[15:8];
        if (hit(bus_addr, MASK_LO))   bus_rdata = mask_q[7:0];
        if (hit(bus_addr, PEND_HI))   bus_rdata = pend_q[15:8];
        if (hit(bus_addr, PEND_LO))   bus_rdata = pend_q[7:0];
        if (hit(bus_addr, STAT_ADDR)) bus_rdata = stat_q;
        if (hit(bus_addr, SWT_VADDR)) bus_rdata = swt_vec;
        if (hit(bus_addr, SP0_VADDR)) bus_rdata = sp0_vec;
        if (hit(bus_addr, SP1_VADDR)) bus_rdata = sp1_vec;
    end
endmodule

// File: rtl/pic_arb.sv
module pic_arb
    import pic_pkg::*;
#(
    parameter int NSRC = 13,
    localparam int IW  = $clog2(NSRC + 1)
) (
    input  logic [NSRC:1]      req,
    input  logic [NSRC:1]      msk,
    input  logic [NSRC:1][4:0] prio,
    input  logic [NSRC:1]      auto_f,
    output logic               win_valid,
    output logic [IW-1:0]      win_idx,
    output logic [2:0]         win_lvl,
    output logic               win_auto
);
    logic [4:0] best;

    // scan upward; strict compare keeps the lowest index on ties
    always_comb begin
        best     = '0;
        win_idx  = '0;
        win_auto = 1'b0;
        for (int n = 1; n <= NSRC; n++) begin
            if (req[n] && !msk[n] && prio[n] > best) begin
                best     = prio[n];
                win_idx  = IW'(n);
                win_auto = auto_f[n];
            end
        end
        win_valid = best >= MIN_PRIO;
        win_lvl   = best[4:2];
    end
endmodule

// File: rtl/pic_vec.sv
module pic_vec
    import pic_pkg::*;
#(
    parameter int NSRC = 13,
    localparam int IW  = $clog2(NSRC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_valid,
    input  logic [IW-1:0] win_idx,
    input  logic [2:0]    win_lvl,
    input  logic          win_auto,
    input  logic [7:0]    swt_vec,
    input  logic [7:0]    sp0_vec,
    input  logic [7:0]    sp1_vec,
    output logic [2:0]    irq_level,
    output logic [7:0]    irq_vector
);
    logic [2:0] lvl_d;
    logic [7:0] vec_d;

    always_comb begin
        lvl_d = win_valid ? win_lvl : 3'd0;
        if (!win_valid)                  vec_d = 8'd0;
        else if (win_auto)               vec_d = AUTOV_BASE + {5'd0, win_lvl};
        else if (win_idx == IW'(SWT_SRC)) vec_d = swt_vec;
        else if (win_idx == IW'(SP0_SRC)) vec_d = sp0_vec;
        else if (win_idx == IW'(SP1_SRC)) vec_d = sp1_vec;
        else                             vec_d = VEC_FALLBK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_level  <= '0;
            irq_vector <= '0;
        end else begin
            irq_level  <= lvl_d;
            irq_vector <= vec_d;
        end
    end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import pic_pkg::*;
#(
    parameter int NSRC = 13,
    parameter int AW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [13:1]   irq_req,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    output logic [2:0]    irq_level,
    output logic [7:0]    irq_vector
);
    localparam int IW = $clog2(NSRC + 1);

    logic [NSRC:1][4:0] src_prio;
    logic [NSRC:1]      src_auto;
    logic [15:0]        pend_q, mask_q;
    logic [7:0]         stat_q, swt_vec, sp0_vec, sp1_vec;
    logic               win_valid, win_auto;
    logic [IW-1:0]      win_idx;
    logic [2:0]         win_lvl;

    pic_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req[NSRC:1]),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_prio(src_prio), .src_auto(src_auto),
        .pend_q(pend_q), .mask_q(mask_q), .stat_q(stat_q),
        .swt_vec(swt_vec), .sp0_vec(sp0_vec), .sp1_vec(sp1_vec)
    );

    pic_arb #(.NSRC(NSRC)) u_arb (
        .req(pend_q[NSRC:1]), .msk(mask_q[NSRC:1]), .prio(src_prio),
        .auto_f(src_auto), .win_valid(win_valid), .win_idx(win_idx),
        .win_lvl(win_lvl), .win_auto(win_auto)
    );

    pic_vec #(.NSRC(NSRC)) u_vec (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_idx(win_idx),
        .win_lvl(win_lvl), .win_auto(win_auto), .swt_vec(swt_vec),
        .sp0_vec(sp0_vec), .sp1_vec(sp1_vec),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );
endmodule

// File: rtl/prio_vec_intc_chk.sv
module prio_vec_intc_chk
    import pic_pkg::*;
#(
    parameter int NSRC = 13,
    parameter int AW   = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [13:1]   irq_req,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic [7:0]    bus_wdata,
    input logic [2:0]    irq_level,
    input logic [7:0]    irq_vector,
    input logic [15:0]   pend,
    input logic [15:0]   mask,
    input logic [7:0]    stat,
    input logic          win_valid,
    input logic [2:0]    win_lvl,
    input logic          win_auto
);
    // R5: no level means no vector
    a_r5_idle_no_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level == 3'd0 |-> irq_vector == 8'd0);

    // R3: nothing unmasked and pending gives level 0 next cycle
    a_r3_all_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~mask) == 16'd0) |=> irq_level == 3'd0);

    // R2: pending copies the request lines
    a_r2_pend_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend[NSRC:1] == $past(irq_req[NSRC:1]));

    // R6 / R11: level registered from the winner
    a_r6_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |=> irq_level == $past(win_lvl));

    // R7: autovector arithmetic
    a_r7_autovector: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_auto) |=> irq_vector == AUTOV_BASE + {5'd0, irq_level});

    // R10: write-one-to-clear
    a_r10_stat_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(STAT_ADDR)) |=> stat == ($past(stat) & ~$past(bus_wdata)));

    // R10: never gains a bit
    a_r10_stat_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat & ~$past(stat)) == 8'd0);

    // R2: unused pending bits stay clear
    a_r2_pend_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pend[0] == 1'b0 && pend[15:14] == 2'b00);

    logic unused_ok;
    assign unused_ok = ^{irq_req, pend};
endmodule

bind prio_vec_intc prio_vec_intc_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .irq_level(irq_level),
    .irq_vector(irq_vector), .pend(pend_q), .mask(mask_q), .stat(stat_q),
    .win_valid(win_valid), .win_lvl(win_lvl), .win_auto(win_auto)
);

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:1] irq_req = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    logic [7:0]  m_ctl [1:13];
    logic [15:0] m_mask;
    logic [7:0]  m_swt, m_sp0, m_sp1, m_stat;

    always #4 clk = ~clk;

    prio_vec_intc u_prio_vec_intc (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int n = 1; n <= 13; n++)
            m_ctl[n] = (n <= 7) ? 8'(4 * n) : (n == 8) ? 8'h1C : (n <= 11) ? 8'h80 : 8'h00;
        m_mask = 16'h3FFE;
        m_swt = 8'h0F; m_sp0 = 8'h0F; m_sp1 = 8'h0F;
        m_stat = 8'h80;
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a >= 8'h14 && a <= 8'h20) m_ctl[a - 8'h13] = d;
        else if (a == 8'h36) m_mask[15:8] = d;
        else if (a == 8'h37) m_mask[7:0] = d;
        else if (a == 8'h40) m_stat = m_stat & ~d;
        else if (a == 8'h42) m_swt = d;
        else if (a == 8'h44) m_sp0 = d;
        else if (a == 8'h45) m_sp1 = d;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [10:0] model_out();
        logic [4:0] best = '0;
        int w = 0;
        logic [2:0] l;
        logic [7:0] v;
        for (int n = 1; n <= 13; n++)
            if (irq_req[n] && !m_mask[n] && m_ctl[n][4:0] > best) begin
                best = m_ctl[n][4:0]; w = n;
            end
        if (best < 5'd4) return 11'd0;
        l = best[4:2];
        if (m_ctl[w][7])  v = 8'd24 + {5'd0, l};
        else if (w == 8)  v = m_swt;
        else if (w == 12) v = m_sp0;
        else if (w == 13) v = m_sp1;
        else              v = 8'h0F;
        return {l, v};
    endfunction

    task automatic settle_and_check(string tag);
        repeat (2) @(negedge clk);
        check({tag, " level"}, 16'(irq_level), 16'(model_out() >> 8));
        check({tag, " vector"}, 16'(irq_vector), 16'(model_out() & 11'hFF));
    endtask

    task automatic set_irq(logic [13:1] v);
        @(negedge clk);
        irq_req = v;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] d;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 level", 16'(irq_level), 16'd0);
        check("R1 vector", 16'(irq_vector), 16'd0);
        for (int n = 1; n <= 13; n++) begin
            rd(8'(8'h13 + n), d);
            check($sformatf("R1 R9 ctl%0d", n), 16'(d), 16'(m_ctl[n]));
        end
        rd(8'h36, d); check("R1 mask hi", 16'(d), 16'h3F);
        rd(8'h37, d); check("R1 mask lo", 16'(d), 16'hFE);
        rd(8'h42, d); check("R1 swt vec", 16'(d), 16'h0F);
        rd(8'h44, d); check("R1 sp0 vec", 16'(d), 16'h0F);
        rd(8'h45, d); check("R1 sp1 vec", 16'(d), 16'h0F);
        rd(8'h40, d); check("R1 status", 16'(d), 16'h80);

        // R3 all masked: requests have no effect
        set_irq(13'h1FFF);
        settle_and_check("R3 masked");
        check("R3 masked level 0", 16'(irq_level), 16'd0);

        // R2 pending readback and read-only
        rd(8'h3A, d); check("R2 pend hi", 16'(d), 16'h3F);
        rd(8'h3B, d); check("R2 pend lo", 16'(d), 16'hFE);
        set_irq(13'h0000);
        wr(8'h3B, 8'hFF);
        rd(8'h3B, d); check("R2 pend write ignored", 16'(d), 16'h00);
        settle_and_check("R2 pend no forge");

        // R9 unmapped address
        wr(8'h50, 8'hAA);
        rd(8'h50, d); check("R9 unmapped reads 0", 16'(d), 16'h00);

        // unmask all
        wr(8'h36, 8'h00); wr(8'h37, 8'h00);

        // R4 tie: sources 3 and 6 both 0x0C, lowest wins (3, fallback)
        wr(8'h16, 8'h0C); wr(8'h19, 8'h0C);
        wr(8'h42, 8'h55);
        set_irq(13'b0000000100100);
        settle_and_check("R4 tie");
        check("R4 tie vector fallback", 16'(irq_vector), 16'h0F);
        check("R6 tie level", 16'(irq_level), 16'd3);

        // R5 winner below 4
        wr(8'h16, 8'h03); wr(8'h19, 8'h02);
        settle_and_check("R5 low prio");
        check("R5 level 0", 16'(irq_level), 16'd0);
        check("R5 vector 0", 16'(irq_vector), 16'd0);

        // R8 source 8 with watchdog vector
        wr(8'h1B, 8'h1D);
        set_irq(13'b0000010000000);
        settle_and_check("R8 src8");
        check("R8 src8 vector", 16'(irq_vector), 16'h55);

        // R7 autovector on source 8
        wr(8'h1B, 8'h94);
        settle_and_check("R7 autovec");
        check("R7 autovec value", 16'(irq_vector), 16'd29);

        // R8 sources 12 and 13
        wr(8'h44, 8'h61); wr(8'h45, 8'h62);
        wr(8'h1F, 8'h10); wr(8'h20, 8'h14);
        set_irq(13'b1100000000000);
        settle_and_check("R8 src13");
        check("R8 src13 vector", 16'(irq_vector), 16'h62);
        set_irq(13'b0100000000000);
        settle_and_check("R8 src12");
        check("R8 src12 vector", 16'(irq_vector), 16'h61);

        // R11 latency from a request line: old value after 1 edge, new after 2
        wr(8'h14, 8'h1C);
        set_irq(13'b0000000000000);
        settle_and_check("R11 idle");
        set_irq(13'b0000000000001);
        @(negedge clk);
        check("R11 one edge level unchanged", 16'(irq_level), 16'd0);
        @(negedge clk);
        check("R11 two edges level", 16'(irq_level), 16'd7);
        check("R11 two edges vector", 16'(irq_vector), 16'h0F);

        // R11 latency from a mask write: new value one edge after the write edge
        @(negedge clk);
        bus_addr = 8'h37; bus_wdata = 8'h02; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; m_mask[7:0] = 8'h02;
        check("R11 mask write not yet", 16'(irq_level), 16'd7);
        @(negedge clk);
        check("R11 mask write applied", 16'(irq_level), 16'd0);

        // R10 reset-status write-one-to-clear
        wr(8'h40, 8'h7F);
        rd(8'h40, d); check("R10 zeros kept", 16'(d), 16'h80);
        wr(8'h40, 8'h80);
        rd(8'h40, d); check("R10 cleared", 16'(d), 16'h00);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 5));
            set_irq(13'($urandom));
            case (op)
                0: wr(8'(8'h14 + $urandom_range(0, 12)), 8'($urandom));
                1: wr(8'(8'h14 + $urandom_range(0, 12)), 8'($urandom) & 8'h9F);
                2: wr(($urandom_range(0, 1) == 0) ? 8'h36 : 8'h37, 8'($urandom) & 8'h55);
                3: wr((i % 3 == 0) ? 8'h42 : (i % 3 == 1) ? 8'h44 : 8'h45, 8'($urandom));
                default: ;
            endcase
            settle_and_check($sformatf("R4 R6 R7 R8 random %0d", i));
            if (i % 25 == 0) begin
                rd(8'h3B, d);
                check("R2 random pend lo", 16'(d), 16'({irq_req[7:1], 1'b0}));
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule